// File: doc/BRIEF.md
# Per-Register Vector Mode State

This block keeps a 4-bit mode word for every architectural integer register. The low two bits of a word give the sub-vector length and the high two bits give the kind of operand (scalar, plain vector, or predicated vector). Each retiring instruction can rewrite the word of its destination register through one update port. Several read ports return the words of the source registers together with a small decode of each word. Software sees the whole state as a row of XLEN-wide chunks, each selected by a chunk index, and can read or replace any chunk.

A shadow copy supports traps. On trap entry the live state is copied into the shadow and the live state becomes all-scalar with sub-vector length 1. On trap return the live state is reloaded from the shadow. A separate clear command zeroes the live state without touching the shadow, so that scalar code can be called cheaply. Register 0 has no mode: its word is held at zero.

Top module: `vmode_state`

## Requirements
- R1: After reset the live state and the shadow copy are both zero, so every read port and CSR chunk reads zero, and a trap return as the first event leaves the live state zero.
- R2: A destination update (dst_we high, no higher-priority event) with index r in 1..NUM_REGS-1 replaces word r with dst_mode; the new value appears on the read ports and the CSR window from the cycle after the clock edge, and other words keep their values.
- R3: Word 0 always reads zero: a destination update to index 0 changes nothing, and a CSR write to chunk 0 keeps bits 3:0 at zero.
- R4: Word r occupies bits 4r+3:4r of the state; chunk k holds state bits k*XLEN+XLEN-1 down to k*XLEN. A CSR write replaces the whole chunk at the next edge and a CSR read returns it combinationally.
- R5: Trap entry copies the live state into the shadow and sets the live state to zero at the same edge.
- R6: Trap return reloads the live state from the shadow and leaves the shadow unchanged.
- R7: The clear command sets the live state to zero and leaves the shadow unchanged.
- R8: When several events occur in one cycle only the highest-priority one acts, in the order trap entry, trap return, clear command, CSR write, destination update; the shadow changes only on trap entry.
- R9: For each read port with word w: src_mode is w, src_subvl is w[1:0]+1 (codes 00..11 give 1..4), src_vec is high when w[3:2] is not 00 (01 plain vector, 1x predicated), and src_pred equals w[3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_enter | input | 1 | Save live state to shadow and zero the live state |
| trap_return | input | 1 | Reload live state from shadow |
| clear_all | input | 1 | Zero the live state |
| csr_we | input | 1 | Replace the selected chunk with csr_wdata |
| csr_idx | input | CIDX_W | Chunk index for CSR read and write |
| csr_wdata | input | XLEN | Chunk write data |
| csr_rdata | output | XLEN | Selected chunk of the live state |
| dst_we | input | 1 | Destination word update strobe |
| dst_idx | input | RIDX_W | Destination register index |
| dst_mode | input | 4 | New mode word for the destination |
| src_idx | input | NUM_SRC*RIDX_W | Source register index per read port |
| src_mode | output | NUM_SRC*4 | Mode word per read port |
| src_subvl | output | NUM_SRC*3 | Decoded sub-vector length per read port, 1 to 4 |
| src_vec | output | NUM_SRC | Word marks a vector operand |
| src_pred | output | NUM_SRC | Word marks a predicated vector operand |

## Verification
The bench builds the block with 16 registers, a 32-bit XLEN and two read ports, giving a 64-bit state in two chunks. At that size every destination index, every one of the 16 mode values and every word of the state can be read back after each step, and all 32 combinations of the five event inputs are applied against a loaded live state and a distinct shadow. That brings the whole priority order, the chunk split and the register 0 rule within reach of an exhaustive comparison against an arithmetic model.

// File: rtl/vmode_pkg.sv
package vmode_pkg;

    localparam int FIELD_W = 4;
    localparam int SVL_W   = 3;

    typedef enum logic [1:0] {
        KIND_SCALAR = 2'b00,
        KIND_VECTOR = 2'b01,
        KIND_PRED_A = 2'b10,
        KIND_PRED_B = 2'b11
    } vkind_e;

    typedef struct packed {
        vkind_e     kind;
        logic [1:0] svl_code;
    } vmode_t;

    function automatic logic [SVL_W-1:0] svl_length(input logic [1:0] code);
        return {1'b0, code} + 3'd1;
    endfunction

    function automatic logic kind_is_vector(input vkind_e k);
        return k != KIND_SCALAR;
    endfunction

    function automatic logic kind_is_pred(input vkind_e k);
        return (k == KIND_PRED_A) || (k == KIND_PRED_B);
    endfunction

endpackage

// File: rtl/vmode_store.sv
module vmode_store #(
    parameter int NUM_REGS = 32,
    parameter int XLEN     = 32,
    parameter int STATE_W  = NUM_REGS * vmode_pkg::FIELD_W,
    parameter int CHUNKS   = STATE_W / XLEN,
    parameter int CIDX_W   = 1,
    parameter int RIDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_enter,
    input  logic               trap_return,
    input  logic               clear_all,
    input  logic               csr_we,
    input  logic [CIDX_W-1:0]  csr_idx,
    input  logic [XLEN-1:0]    csr_wdata,
    input  logic               dst_we,
    input  logic [RIDX_W-1:0]  dst_idx,
    input  logic [3:0]         dst_mode,
    output logic [STATE_W-1:0] live_o
);
    import vmode_pkg::*;

    localparam logic [STATE_W-1:0] KEEP_MASK = {{(STATE_W-FIELD_W){1'b1}}, {FIELD_W{1'b0}}};

    typedef struct packed {
        logic [STATE_W-1:0] live;
        logic [STATE_W-1:0] shadow;
    } store_t;

    store_t st_d, st_q;

    logic [STATE_W-1:0] csr_merged;
    logic [STATE_W-1:0] dst_merged;

    // Chunk-replaced copy of the live state
    for (genvar k = 0; k < CHUNKS; k++) begin : g_chunk
        assign csr_merged[k*XLEN +: XLEN] =
            (csr_idx == CIDX_W'(k)) ? csr_wdata : st_q.live[k*XLEN +: XLEN];
    end

    // Word-replaced copy of the live state
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
        assign dst_merged[r*FIELD_W +: FIELD_W] =
            (dst_idx == RIDX_W'(r)) ? dst_mode : st_q.live[r*FIELD_W +: FIELD_W];
    end

    always_comb begin
        st_d = st_q;
        if (trap_enter) begin
            st_d.shadow = st_q.live;
            st_d.live   = '0;
        end else if (trap_return) begin
            st_d.live = st_q.shadow;
        end else if (clear_all) begin
            st_d.live = '0;
        end else if (csr_we) begin
            st_d.live = csr_merged & KEEP_MASK;
        end else if (dst_we && (dst_idx != '0)) begin
            st_d.live = dst_merged & KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live_o = st_q.live;

    function automatic logic [3:0] word_at(input logic [STATE_W-1:0] v,
                                           input logic [RIDX_W-1:0] i);
        return v[int'(i)*FIELD_W +: FIELD_W];
    endfunction

    function automatic logic [XLEN-1:0] chunk_at(input logic [STATE_W-1:0] v,
                                                 input logic [CIDX_W-1:0] i);
        return v[int'(i)*XLEN +: XLEN];
    endfunction

    assert_trap_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter |=> (st_q.shadow == $past(st_q.live)) && (st_q.live == '0));

    assert_trap_ret_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_enter && trap_return) |=>
            (st_q.live == $past(st_q.shadow)) && $stable(st_q.shadow));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_enter && !trap_return && clear_all) |=>
            (st_q.live == '0) && $stable(st_q.shadow));

    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_enter |=> $stable(st_q.shadow));

    assert_dst_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_enter && !trap_return && !clear_all && !csr_we && dst_we && dst_idx != '0)
            |=> word_at(st_q.live, $past(dst_idx)) == $past(dst_mode));

    assert_dst_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_enter && !trap_return && !clear_all && !csr_we && dst_we && dst_idx == '0)
            |=> $stable(st_q.live));

    assert_csr_chunk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_enter && !trap_return && !clear_all && csr_we &&
         csr_idx != '0 && int'(csr_idx) < CHUNKS)
            |=> chunk_at(st_q.live, $past(csr_idx)) == $past(csr_wdata));

endmodule

// File: rtl/vmode_src_port.sv
module vmode_src_port #(
    parameter int NUM_REGS = 32,
    parameter int STATE_W  = NUM_REGS * vmode_pkg::FIELD_W,
    parameter int RIDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] live,
    input  logic [RIDX_W-1:0]  idx,
    output logic [3:0]         mode,
    output logic [2:0]         subvl,
    output logic               is_vec,
    output logic               is_pred
);
    import vmode_pkg::*;

    vmode_t word;

    always_comb begin
        word    = vmode_t'(live[int'(idx)*FIELD_W +: FIELD_W]);
        mode    = word;
        subvl   = svl_length(word.svl_code);
        is_vec  = kind_is_vector(word.kind);
        is_pred = kind_is_pred(word.kind);
    end

    assert_src_r0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == '0) |-> (mode == 4'd0));

endmodule

// File: rtl/vmode_csr_window.sv
module vmode_csr_window #(
    parameter int STATE_W = 128,
    parameter int XLEN    = 32,
    parameter int CHUNKS  = STATE_W / XLEN,
    parameter int CIDX_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] live,
    input  logic [CIDX_W-1:0]  idx,
    output logic [XLEN-1:0]    rdata
);
    always_comb begin
        rdata = '0;
        for (int k = 0; k < CHUNKS; k++) begin
            if (idx == CIDX_W'(k)) begin
                rdata = live[k*XLEN +: XLEN];
            end
        end
    end

    assert_win_word0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == '0) |-> (rdata[3:0] == 4'd0));

endmodule

// File: rtl/vmode_state.sv
module vmode_state #(
    parameter int NUM_REGS = 32,
    parameter int XLEN     = 32,
    parameter int NUM_SRC  = 3,
    localparam int STATE_W = NUM_REGS * vmode_pkg::FIELD_W,
    localparam int CHUNKS  = STATE_W / XLEN,
    localparam int CIDX_W  = (CHUNKS > 1) ? $clog2(CHUNKS) : 1,
    localparam int RIDX_W  = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      trap_enter,
    input  logic                      trap_return,
    input  logic                      clear_all,
    input  logic                      csr_we,
    input  logic [CIDX_W-1:0]         csr_idx,
    input  logic [XLEN-1:0]           csr_wdata,
    output logic [XLEN-1:0]           csr_rdata,
    input  logic                      dst_we,
    input  logic [RIDX_W-1:0]         dst_idx,
    input  logic [3:0]                dst_mode,
    input  logic [NUM_SRC*RIDX_W-1:0] src_idx,
    output logic [NUM_SRC*4-1:0]      src_mode,
    output logic [NUM_SRC*3-1:0]      src_subvl,
    output logic [NUM_SRC-1:0]        src_vec,
    output logic [NUM_SRC-1:0]        src_pred
);
    logic [STATE_W-1:0] live_w;

    vmode_store #(
        .NUM_REGS (NUM_REGS),
        .XLEN     (XLEN),
        .STATE_W  (STATE_W),
        .CHUNKS   (CHUNKS),
        .CIDX_W   (CIDX_W),
        .RIDX_W   (RIDX_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .trap_enter  (trap_enter),
        .trap_return (trap_return),
        .clear_all   (clear_all),
        .csr_we      (csr_we),
        .csr_idx     (csr_idx),
        .csr_wdata   (csr_wdata),
        .dst_we      (dst_we),
        .dst_idx     (dst_idx),
        .dst_mode    (dst_mode),
        .live_o      (live_w)
    );

    vmode_csr_window #(
        .STATE_W (STATE_W),
        .XLEN    (XLEN),
        .CHUNKS  (CHUNKS),
        .CIDX_W  (CIDX_W)
    ) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live_w),
        .idx   (csr_idx),
        .rdata (csr_rdata)
    );

    for (genvar p = 0; p < NUM_SRC; p++) begin : g_src
        vmode_src_port #(
            .NUM_REGS (NUM_REGS),
            .STATE_W  (STATE_W),
            .RIDX_W   (RIDX_W)
        ) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .live    (live_w),
            .idx     (src_idx[p*RIDX_W +: RIDX_W]),
            .mode    (src_mode[p*4 +: 4]),
            .subvl   (src_subvl[p*3 +: 3]),
            .is_vec  (src_vec[p]),
            .is_pred (src_pred[p])
        );
    end

endmodule

// File: tb/vmode_state_tb.sv
module vmode_state_tb;

    localparam int NR = 16;
    localparam int XL = 32;
    localparam int NS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_enter = 1'b0, trap_return = 1'b0, clear_all = 1'b0;
    logic        csr_we = 1'b0;
    logic [0:0]  csr_idx = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        dst_we = 1'b0;
    logic [3:0]  dst_idx = '0;
    logic [3:0]  dst_mode = '0;
    logic [7:0]  src_idx = '0;
    logic [7:0]  src_mode;
    logic [5:0]  src_subvl;
    logic [1:0]  src_vec, src_pred;

    logic [63:0] m_live = '0, m_shadow = '0;
    int n_vec = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    vmode_state #(.NUM_REGS(NR), .XLEN(XL), .NUM_SRC(NS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .trap_enter(trap_enter), .trap_return(trap_return), .clear_all(clear_all),
        .csr_we(csr_we), .csr_idx(csr_idx), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .dst_we(dst_we), .dst_idx(dst_idx), .dst_mode(dst_mode),
        .src_idx(src_idx), .src_mode(src_mode), .src_subvl(src_subvl),
        .src_vec(src_vec), .src_pred(src_pred)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every word on both read ports and both CSR chunks with the model
    task automatic check_all(input string req);
        for (int r = 0; r < NR; r++) begin
            logic [3:0] e0, e1;
            src_idx = {4'(NR-1-r), 4'(r)};
            #1;
            e0 = m_live[r*4 +: 4];
            e1 = m_live[(NR-1-r)*4 +: 4];
            chk(req, {28'd0, src_mode[3:0]}, {28'd0, e0});
            chk(req, {26'd0, src_subvl[2:0], src_vec[0], src_pred[0]},
                {26'd0, 3'(e0[1:0]) + 3'd1, e0[3:2] != 2'b00, e0[3]});
            chk(req, {28'd0, src_mode[7:4]}, {28'd0, e1});
        end
        for (int c = 0; c < 2; c++) begin
            csr_idx = 1'(c);
            #1;
            chk(req, csr_rdata, m_live[c*32 +: 32]);
        end
        csr_idx = '0;
    endtask

    task automatic apply(input bit te, input bit tr, input bit cl,
                         input bit cw, input bit ci, input logic [31:0] cd,
                         input bit dw, input logic [3:0] di, input logic [3:0] dm);
        @(negedge clk);
        trap_enter = te; trap_return = tr; clear_all = cl;
        csr_we = cw; csr_idx = ci; csr_wdata = cd;
        dst_we = dw; dst_idx = di; dst_mode = dm;
        @(posedge clk);
        if (te) begin
            m_shadow = m_live;
            m_live = '0;
        end else if (tr) begin
            m_live = m_shadow;
        end else if (cl) begin
            m_live = '0;
        end else if (cw) begin
            m_live[int'(ci)*32 +: 32] = cd;
            m_live[3:0] = 4'd0;
        end else if (dw && di != 4'd0) begin
            m_live[int'(di)*4 +: 4] = dm;
        end
        #1;
        trap_enter = 0; trap_return = 0; clear_all = 0;
        csr_we = 0; csr_idx = '0; dst_we = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all("R1");
        apply(0, 0, 0, 0, 0, 0, 1, 4'd9, 4'hB);
        apply(0, 1, 0, 0, 0, 0, 0, 0, 0);
        check_all("R1");

        // R2 / R3: every destination index, index 0 ignored
        for (int r = 0; r < NR; r++) begin
            apply(0, 0, 0, 0, 0, 0, 1, 4'(r), 4'((r*7 + 5) & 15));
            check_all(r == 0 ? "R3" : "R2");
        end

        // R9: every mode value through the decode
        for (int m = 0; m < 16; m++) begin
            apply(0, 0, 0, 0, 0, 0, 1, 4'd5, 4'(m));
            check_all("R9");
        end

        // R4 / R3: chunk writes, word 0 forced to zero
        apply(0, 0, 0, 1, 0, 32'hDEADBEEF, 0, 0, 0);
        check_all("R4");
        apply(0, 0, 0, 1, 1, 32'h13579BDF, 0, 0, 0);
        check_all("R4");
        apply(0, 0, 0, 0, 0, 0, 1, 4'd0, 4'hF);
        check_all("R3");

        // R5 / R6: save, clear, update in trap, restore
        apply(1, 0, 0, 0, 0, 0, 0, 0, 0);
        check_all("R5");
        apply(0, 0, 0, 0, 0, 0, 1, 4'd3, 4'h6);
        check_all("R2");
        apply(0, 1, 0, 0, 0, 0, 0, 0, 0);
        check_all("R6");

        // R7: clear keeps shadow, proven by a following restore
        apply(0, 0, 0, 0, 0, 0, 1, 4'd12, 4'h9);
        apply(0, 0, 1, 0, 0, 0, 0, 0, 0);
        check_all("R7");
        apply(0, 1, 0, 0, 0, 0, 0, 0, 0);
        check_all("R7");

        // R8: all combinations of the five events
        for (int e = 0; e < 32; e++) begin
            apply(0, 0, 0, 1, 0, 32'hA5C3_96F0 ^ 32'(e * 32'h0101_0101), 0, 0, 0);
            apply(0, 0, 0, 1, 1, 32'h2468_ACE1 + 32'(e), 0, 0, 0);
            apply(e[4], e[3], e[2], e[1], e[0], 32'h7E81_42BD, e[0], 4'(e % 15 + 1), 4'(e));
            check_all("R8");
        end

        finish_run();
    end

endmodule